// File: doc/BRIEF.md
# Self-test observation register

This block is a register bank that wraps a combinational logic cloud and supports its self-test. A 2-bit mode input selects one of four behaviours. In functional mode the register simply captures its parallel inputs. In scan mode the bits form a serial shift chain between a scan input and a scan output. In clear mode the register loads zeros. In test mode the register runs as a linear-feedback pseudo-random pattern generator, and on the same clock edge it folds its parallel inputs into a running multiple-input signature.

In a self-test session a first register drives patterns into the logic cloud. A second register, also in test mode, compacts the cloud's responses. After a chosen number of test cycles the signature can be read from the parallel output or shifted out through the scan chain. It is then compared outside the block against a stored expected value. The width and the feedback tap mask are parameters. The synchronous reset loads all ones, so pattern generation starts from a nonzero state.

Top module: `obs_register`

## Requirements
- R1: While `rst` is high at a rising edge, every bit of `q` becomes 1 after that edge.
- R2: With mode code 2'b11 (functional), `q` takes the value of `d` on the next rising edge.
- R3: With mode code 2'b00 (scan), the register shifts toward the most significant bit on each edge. `si` enters bit 0, and each bit i > 0 takes the old bit i-1.
- R4: With mode code 2'b10 (clear), `q` becomes all zeros on the next rising edge.
- R5: With mode code 2'b01 (test) and `d` at zero, the register shifts toward the MSB and bit 0 takes the XOR of the state bits selected by `TAPS` (default 3'b101, bits 2 and 0). From 111 the default register steps through 110, 101, 010, 100, 001, 011 and back to 111.
- R6: In test mode each next-state bit i is additionally XORed with `d[i]`, which compacts `d` into a signature.
- R7: In test mode with `d` at zero, a nonzero state never becomes zero.
- R8: `rst` takes priority over every mode code.
- R9: `d` has no effect in scan mode, and `si` has no effect in functional, clear or test mode.
- R10: `so` always equals `q[W-1]`, so it is a registered output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, loads all ones |
| mode | input | 2 | 00 scan, 01 test, 10 clear, 11 functional |
| d | input | W | Parallel data or response input |
| si | input | 1 | Serial scan input into bit 0 |
| q | output | W | Registered state / parallel output |
| so | output | 1 | Serial scan output, the state MSB |

## Verification
In test mode, pattern generation and signature compaction happen on the same edge. The feedback value shifted into bit 0 and the shifted bits are all XORed with the parallel input at once. The bench provokes this by applying nonzero `d` words while the generator runs from known states. It judges every resulting state against a next-state model built from the requirements. The plain generator sequence is also checked against the literal 7-state list. A second overlap, reset asserted alongside every mode code, is judged by the all-ones result.

// File: rtl/obs_pkg.sv
package obs_pkg;
  typedef enum logic [1:0] {
    MODE_SCAN  = 2'b00,
    MODE_GEN   = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_FUNC  = 2'b11
  } obs_mode_e;
endpackage

// File: rtl/obs_feedback.sv
module obs_feedback #(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic [W-1:0] state,
  output logic         fb
);
  // parity of the tapped state bits, fed into bit 0 (R5)
  assign fb = ^(state & TAPS);
endmodule

// File: rtl/obs_slice.sv
module obs_slice
  import obs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  obs_mode_e mode,
  input  logic      d_bit,
  input  logic      scan_src,
  input  logic      gen_src,
  output logic      q_bit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_bit <= 1'b1;                     // R1, R8
    end else begin
      unique case (mode)
        MODE_SCAN:  q_bit <= scan_src;          // R3
        MODE_GEN:   q_bit <= gen_src ^ d_bit;   // R5, R6
        MODE_CLEAR: q_bit <= 1'b0;              // R4
        default:    q_bit <= d_bit;             // R2
      endcase
    end
  end
endmodule

// File: rtl/obs_register.sv
module obs_register
  import obs_pkg::*;
#(
  parameter int W = 3,
  parameter logic [W-1:0] TAPS = 3'b101
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] d,
  input  logic         si,
  output logic [W-1:0] q,
  output logic         so
);
  localparam int MSB = W - 1;

  obs_mode_e mode_e;
  logic      fb;
  logic [W-1:0] scan_src;
  logic [W-1:0] gen_src;

  assign mode_e = obs_mode_e'(mode);

  obs_feedback #(.W(W), .TAPS(TAPS)) u_fb (
    .state (q),
    .fb    (fb)
  );

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_head
      assign scan_src[i] = si;
      assign gen_src[i]  = fb;
    end else begin : g_body
      assign scan_src[i] = q[i-1];
      assign gen_src[i]  = q[i-1];
    end
    obs_slice u_slice (
      .clk      (clk),
      .rst      (rst),
      .mode     (mode_e),
      .d_bit    (d[i]),
      .scan_src (scan_src[i]),
      .gen_src  (gen_src[i]),
      .q_bit    (q[i])
    );
  end

  assign so = q[MSB];   // R10

  assert_func_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_FUNC) |=> (q == $past(d)));

  assert_scan_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_SCAN) |=> (q == {$past(q[MSB-1:0]), $past(si)}));

  assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_CLEAR) |=> (q == '0));

  assert_gen_compact_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_GEN) |=>
      (q == ({$past(q[MSB-1:0]), ^($past(q) & TAPS)} ^ $past(d))));

  assert_gen_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_GEN && d == '0 && q != '0) |=> (q != '0));
endmodule

// File: tb/obs_register_bench.sv
`timescale 1ns/1ps
module obs_register_bench;
  localparam int W = 3;
  localparam logic [W-1:0] TAPS = 3'b101;

  typedef struct {
    logic [W-1:0] q;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b11;
  logic [W-1:0] d = '0;
  logic si = 1'b0;
  logic [W-1:0] q;
  logic so;

  exp_t sb[$];
  int vectors = 0;
  int misses = 0;
  logic [W-1:0] model_s = '1;

  always #2 clk = ~clk;

  obs_register #(.W(W), .TAPS(TAPS)) u_obs_register (
    .clk(clk), .rst(rst), .mode(mode), .d(d), .si(si), .q(q), .so(so)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] s, logic r,
                                              logic [1:0] m, logic [W-1:0] dv, logic sv);
    logic [W-1:0] n;
    if (r) return '1;
    case (m)
      2'b00: n = {s[W-2:0], sv};
      2'b01: n = {s[W-2:0], ^(s & TAPS)} ^ dv;
      2'b10: n = '0;
      default: n = dv;
    endcase
    return n;
  endfunction

  task automatic drive(input logic r, input logic [1:0] m, input logic [W-1:0] dv,
                       input logic sv, input string tag, input logic [W-1:0] expq);
    @(negedge clk);
    rst = r; mode = m; d = dv; si = sv;
    sb.push_back('{expq, tag});
    model_s = expq;
  endtask

  task automatic run(input logic r, input logic [1:0] m, input logic [W-1:0] dv,
                     input logic sv, input string tag);
    drive(r, m, dv, sv, tag, model_next(model_s, r, m, dv, sv));
  endtask

  // monitor: compare each result one time unit after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      vectors++;
      if (q !== it.q || so !== it.q[W-1]) begin
        misses++;
        $display("FAIL %s: q=%b so=%b expected q=%b so=%b", it.tag, q, so, it.q, it.q[W-1]);
      end else if (it.tag == "R7" && q == '0) begin
        misses++;
        $display("FAIL R7: q=%b expected nonzero", q);
      end
    end
  end

  initial begin
    #(4 * 100000);
    misses++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [W-1:0] seq [7] = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
    // R1 reset state
    run(1'b1, 2'b11, 3'b000, 1'b0, "R1");
    // R2 functional capture, several patterns; R9 si toggled and ignored
    run(1'b0, 2'b11, 3'b101, 1'b1, "R2");
    run(1'b0, 2'b11, 3'b010, 1'b0, "R2");
    run(1'b0, 2'b11, 3'b110, 1'b1, "R9");
    // R4 clear
    run(1'b0, 2'b10, 3'b111, 1'b1, "R4");
    // R3 scan shift-in of 1,0,1; R9 d ignored; R10 so follows MSB
    run(1'b0, 2'b00, 3'b111, 1'b1, "R3");
    run(1'b0, 2'b00, 3'b010, 1'b0, "R9");
    run(1'b0, 2'b00, 3'b101, 1'b1, "R3");
    run(1'b0, 2'b00, 3'b000, 1'b0, "R10");
    run(1'b0, 2'b00, 3'b000, 1'b0, "R10");
    // R8 reset overrides every mode
    for (int m = 0; m < 4; m++) run(1'b1, m[1:0], 3'b010, 1'b0, "R8");
    // R5 literal generator sequence from 111
    for (int k = 0; k < 7; k++) drive(1'b0, 2'b01, 3'b000, k[0], "R5", seq[k]);
    // R6 generation and compaction together
    run(1'b0, 2'b01, 3'b011, 1'b0, "R6");
    run(1'b0, 2'b01, 3'b100, 1'b1, "R6");
    run(1'b0, 2'b01, 3'b111, 1'b0, "R6");
    run(1'b0, 2'b01, 3'b001, 1'b0, "R6");
    // R7 free-running generator stays nonzero
    if (model_s == '0) run(1'b0, 2'b11, 3'b001, 1'b0, "R2");
    for (int k = 0; k < 20; k++) run(1'b0, 2'b01, 3'b000, k[1], "R7");
    // R4 clear then R2 capture
    run(1'b0, 2'b10, 3'b000, 1'b0, "R4");
    run(1'b0, 2'b11, 3'b011, 1'b0, "R2");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule